// File: doc/BRIEF.md
# Normalize and Multi-Mode Shift Unit

This block is a sequential shift engine for a 25-bit register chain. The chain is built from a one-bit link, a 12-bit accumulator (AC) and a 12-bit multiplier-quotient word (MQ). A single start strobe launches one of five operations:

- loading the 5-bit step counter;
- normalizing AC:MQ;
- an arithmetic left shift of link:AC:MQ;
- an arithmetic right shift of AC:MQ;
- a logical right shift of AC:MQ.

Every shift moves one bit position per clock. The chain is loaded from the `ac_in`, `mq_in` and `lnk_in` inputs in the cycle that start is accepted. The shift count is taken from the 5-bit `field` input, which carries the low five bits of the operand word.

Control is a four-state machine:

| State | Meaning |
|---|---|
| `S_IDLE` | Waiting for a start strobe |
| `S_NORM` | Normalize in progress, one left shift per clock |
| `S_SHIFT` | Counted shift, one position per clock |
| `S_DONE` | One-cycle completion, drives `done` |

The transitions are named as follows:

| Transition | Path | Condition |
|---|---|---|
| *launch-norm* | `S_IDLE` to `S_NORM` | start with op 1 |
| *launch-shift* | `S_IDLE` to `S_SHIFT` | start with op 2, 3 or 4 |
| *launch-quick* | `S_IDLE` to `S_DONE` | start with op 0 or an unused code |
| *norm-stop* | `S_NORM` to `S_DONE` | the top two AC bits differ, or the cap is reached |
| *count-out* | `S_SHIFT` to `S_DONE` | the shift counter reaches zero |
| *retire* | `S_DONE` to `S_IDLE` | always |

All results stay on the outputs until the next accepted start.

Top module: `shift_norm_unit`

## Requirements
- R1: After reset, `ac`, `mq`, `lnk` and `sc` are zero and `done` is low.
- R2: Op code 0 (load step counter) sets `sc` to the bitwise complement of `field`. It sets `ac`, `mq` and `lnk` to `ac_in`, `mq_in` and `lnk_in`.
- R3: Op code 2 (arithmetic left shift) shifts {lnk, ac, mq} left by `field`+1 places. Zeros enter at mq[0], and bits leaving the link are lost.
- R4: Op code 3 (arithmetic right shift) shifts {ac, mq} right by `field`+1 places. Every vacated position, and the link, receive ac[11], the most significant bit. Bits leaving mq[0] are lost.
- R5: Op code 4 (logical right shift) shifts {ac, mq} right by `field`+1 places with zero fill, and clears the link.
- R6: Op codes 2, 3 and 4 leave `sc` unchanged.
- R7: Op code 1 (normalize) shifts {lnk, ac, mq} left, with zero entering mq[0], until ac[11] differs from ac[10]. It stops after at most 23 shifts and leaves the number of shifts in `sc`. An already normalized value is not shifted.
- R8: Count the edge that accepts start as edge 1. `done` is high after edge `field`+3 for op codes 2 to 4. It is high after edge k+2 for normalize with k shifts, and after edge 1 for every other code.
- R9: `done` is high for exactly one cycle, and results hold unchanged after it until the next start.
- R10: A start strobe while an operation is in progress is ignored.
- R11: Op codes 5 to 7 load `ac`, `mq` and `lnk` from the inputs and leave `sc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| op | input | 3 | Operation select (0 load SC, 1 normalize, 2 left, 3 arithmetic right, 4 logical right) |
| field | input | 5 | Low five operand bits: shift count minus one, or the step-counter source |
| ac_in | input | 12 | AC value loaded at start |
| mq_in | input | 12 | MQ value loaded at start |
| lnk_in | input | 1 | Link value loaded at start |
| ac | output | 12 | Accumulator |
| mq | output | 12 | Multiplier-quotient word |
| lnk | output | 1 | Link bit |
| sc | output | 5 | Step counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal count shows up directly at the ports. If the shift counter is off by one, `done` rises one edge early or late, and the chain settles one position away from its expected value. A corrupted step counter appears in `sc` at the `done` pulse of a normalize. A wrong fill or link rule appears on the very next edge after the first shift, because the link and the top AC bit are visible every cycle. A leaked start appears as a reloaded chain before `done`, so the final values no longer match a model that ignores the strobe.

// File: rtl/snu_pkg.sv
package snu_pkg;
    localparam logic [2:0] OP_LDSC = 3'd0;
    localparam logic [2:0] OP_NORM = 3'd1;
    localparam logic [2:0] OP_SHL  = 3'd2;
    localparam logic [2:0] OP_ASR  = 3'd3;
    localparam logic [2:0] OP_LSR  = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_NORM,
        S_SHIFT,
        S_DONE
    } state_e;
endpackage

// File: rtl/snu_step.sv
// One-position move of the link:AC:MQ chain for the selected operation.
module snu_step
    import snu_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [2:0]   op,
    input  logic         lnk_i,
    input  logic [W-1:0] ac_i,
    input  logic [W-1:0] mq_i,
    output logic         lnk_o,
    output logic [W-1:0] ac_o,
    output logic [W-1:0] mq_o
);
    always_comb begin
        case (op)
            OP_NORM, OP_SHL: begin
                {lnk_o, ac_o, mq_o} = {ac_i, mq_i, 1'b0};
            end
            OP_ASR: begin
                lnk_o        = ac_i[W-1];
                {ac_o, mq_o} = {ac_i[W-1], ac_i, mq_i[W-1:1]};
            end
            OP_LSR: begin
                lnk_o        = 1'b0;
                {ac_o, mq_o} = {1'b0, ac_i, mq_i[W-1:1]};
            end
            default: begin
                lnk_o = lnk_i;
                ac_o  = ac_i;
                mq_o  = mq_i;
            end
        endcase
    end
endmodule

// File: rtl/snu_norm_chk.sv
// Stop condition for normalize: top AC bits differ, or the shift cap is hit.
module snu_norm_chk #(
    parameter int W   = 12,
    parameter int SCW = 5
) (
    input  logic [1:0]     ac_top,
    input  logic [SCW-1:0] sc,
    output logic           stop
);
    localparam int CAP = 2*W - 1;

    always_comb begin
        stop = (ac_top[1] ^ ac_top[0]) || (sc == SCW'(CAP));
    end
endmodule

// File: rtl/snu_ctrl.sv
// Sequencer: state register, next-state logic, control outputs, shift counter.
module snu_ctrl
    import snu_pkg::*;
#(
    parameter int SCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic [SCW-1:0] amount,
    input  logic           stop,
    output logic           load,
    output logic           shift_en,
    output logic           sc_ld,
    output logic           sc_clr,
    output logic           sc_inc,
    output logic [2:0]     op_q,
    output state_e         st,
    output logic           done
);
    localparam int CW = SCW + 1;

    state_e        st_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (op == OP_NORM)
                        st_n = S_NORM;
                    else if (op == OP_SHL || op == OP_ASR || op == OP_LSR)
                        st_n = S_SHIFT;
                    else
                        st_n = S_DONE;
                end
            end
            S_NORM:  if (stop) st_n = S_DONE;
            S_SHIFT: if (cnt == '0) st_n = S_DONE;
            S_DONE:  st_n = S_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        shift_en = 1'b0;
        sc_ld    = 1'b0;
        sc_clr   = 1'b0;
        sc_inc   = 1'b0;
        done     = 1'b0;
        unique case (st)
            S_IDLE: begin
                load   = start;
                sc_ld  = start && (op == OP_LDSC);
                sc_clr = start && (op == OP_NORM);
            end
            S_NORM: begin
                shift_en = !stop;
                sc_inc   = !stop;
            end
            S_SHIFT: shift_en = (cnt != '0);
            S_DONE:  done = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            op_q <= OP_LDSC;
        end else if (load) begin
            cnt  <= {1'b0, amount} + CW'(1);
            op_q <= op;
        end else if (st == S_SHIFT && cnt != '0) begin
            cnt  <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
    import snu_pkg::*;
#(
    parameter int W   = 12,
    parameter int SCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic [SCW-1:0] field,
    input  logic [W-1:0]   ac_in,
    input  logic [W-1:0]   mq_in,
    input  logic           lnk_in,
    output logic [W-1:0]   ac,
    output logic [W-1:0]   mq,
    output logic           lnk,
    output logic [SCW-1:0] sc,
    output logic           done
);
    logic         load, shift_en, sc_ld, sc_clr, sc_inc, stop;
    logic [2:0]   op_q;
    state_e       st;
    logic         lnk_n;
    logic [W-1:0] ac_n, mq_n;

    snu_ctrl #(.SCW(SCW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .amount   (field),
        .stop     (stop),
        .load     (load),
        .shift_en (shift_en),
        .sc_ld    (sc_ld),
        .sc_clr   (sc_clr),
        .sc_inc   (sc_inc),
        .op_q     (op_q),
        .st       (st),
        .done     (done)
    );

    snu_norm_chk #(.W(W), .SCW(SCW)) u_norm (
        .ac_top (ac[W-1:W-2]),
        .sc     (sc),
        .stop   (stop)
    );

    snu_step #(.W(W)) u_step (
        .op    (op_q),
        .lnk_i (lnk),
        .ac_i  (ac),
        .mq_i  (mq),
        .lnk_o (lnk_n),
        .ac_o  (ac_n),
        .mq_o  (mq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac  <= '0;
            mq  <= '0;
            lnk <= 1'b0;
        end else if (load) begin
            ac  <= ac_in;
            mq  <= mq_in;
            lnk <= lnk_in;
        end else if (shift_en) begin
            ac  <= ac_n;
            mq  <= mq_n;
            lnk <= lnk_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sc <= '0;
        else if (sc_ld)  sc <= ~field;
        else if (sc_clr) sc <= '0;
        else if (sc_inc) sc <= sc + SCW'(1);
    end
endmodule

// File: rtl/snu_checker.sv
module snu_checker
    import snu_pkg::*;
#(
    parameter int W   = 12,
    parameter int SCW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done,
    input logic [W-1:0]   ac,
    input logic [W-1:0]   mq,
    input logic           lnk,
    input logic [SCW-1:0] sc,
    input state_e         st,
    input logic [2:0]     op_q,
    input logic           shift_en
);
    localparam int CAP = 2*W - 1;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    sc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT) |=> $stable(sc));

    // R4
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && op_q == OP_ASR) |=> (lnk == ac[W-1]) && $stable(ac[W-1]));

    // R5
    lsr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && op_q == OP_LSR) |=> (!lnk && !ac[W-1]));

    // R3
    lsh_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && (op_q == OP_SHL || op_q == OP_NORM)) |=> !mq[0]);

    // R7
    norm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_NORM) |-> ((ac[W-1] != ac[W-2]) || (sc == SCW'(CAP))));

    // R7
    norm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_NORM) |-> (sc <= SCW'(CAP)));

    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(op_q));
endmodule

bind shift_norm_unit snu_checker #(.W(W), .SCW(SCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .ac       (ac),
    .mq       (mq),
    .lnk      (lnk),
    .sc       (sc),
    .st       (st),
    .op_q     (op_q),
    .shift_en (shift_en)
);

// File: tb/tb_shift_norm_unit.sv
`timescale 1ns/1ps
module tb_shift_norm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [4:0]  field = 5'd0;
    logic [11:0] ac_in = '0, mq_in = '0;
    logic        lnk_in = 1'b0;
    logic [11:0] ac, mq;
    logic        lnk, done;
    logic [4:0]  sc;

    int checks = 0;
    int errors = 0;
    logic [4:0] msc = 5'd0;

    logic [24:0] pats [0:5] = '{25'h1_000001, 25'h0_800000, 25'h1_A5C396,
                                25'h0_5A3C69, 25'h1_FFFFFF, 25'h0_123456};

    shift_norm_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .field(field),
        .ac_in(ac_in), .mq_in(mq_in), .lnk_in(lnk_in),
        .ac(ac), .mq(mq), .lnk(lnk), .sc(sc), .done(done)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [24:0] model_shift(input logic [2:0] o,
                                                input logic [24:0] c, input int s);
        logic signed [23:0] xs;
        logic [23:0] x;
        x  = c[23:0];
        xs = c[23:0];
        case (o)
            3'd2:    return c << s;
            3'd3:    begin xs = xs >>> s; return {x[23], 24'(xs)}; end
            default: begin x = x >> s; return {1'b0, x}; end
        endcase
    endfunction

    function automatic int norm_count(input logic [23:0] x);
        int  run = 0;
        bit  same = 1;
        for (int i = 23; i >= 0; i--) begin
            if (same && x[i] == x[23]) run++;
            else same = 0;
        end
        return run - 1;
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [4:0] f,
                          input logic [24:0] c, input bit inject,
                          input logic [24:0] ec, input logic [4:0] es,
                          input int eedges, input string tag);
        int edges;
        @(negedge clk);
        op = o; field = f; lnk_in = c[24]; ac_in = c[23:12]; mq_in = c[11:0];
        start = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && edges < 100) begin
            if (inject && edges == 3) begin
                start = 1'b1; op = 3'd0; field = 5'h0A;
                ac_in = 12'hBEE; mq_in = 12'h123; lnk_in = ~lnk_in;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
        end
        chk("R8", "done edges", edges, eedges);
        chk(tag, "lnk", lnk, ec[24]);
        chk(tag, "ac", ac, ec[23:12]);
        chk(tag, "mq", mq, ec[11:0]);
        chk(tag, "sc", sc, es);
        @(negedge clk);
        chk("R9", "done after pulse", done, 1'b0);
        chk("R9", "chain held", {lnk, ac, mq}, ec);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ac", ac, 0);
        chk("R1", "mq", mq, 0);
        chk("R1", "lnk", lnk, 0);
        chk("R1", "sc", sc, 0);
        chk("R1", "done", done, 0);
        rst_n = 1'b1;

        // R2: every step-counter value
        for (int f = 0; f < 32; f++) begin
            logic [24:0] c;
            c = {f[0], 12'(f * 291), 12'(~(f * 77))};
            msc = ~5'(f);
            run_op(3'd0, 5'(f), c, 0, c, msc, 1, "R2");
        end

        // R3 R4 R5 R6: every count on several patterns
        for (int o = 2; o <= 4; o++) begin
            for (int p = 0; p < 6; p++) begin
                for (int n = 0; n < 32; n++) begin
                    string t;
                    t = (o == 2) ? "R3 R6" : (o == 3) ? "R4 R6" : "R5 R6";
                    run_op(3'(o), 5'(n), pats[p], 0,
                           model_shift(3'(o), pats[p], n + 1), msc, n + 3, t);
                end
            end
        end

        // R7: single ones, single zeros, zero, all ones, normalized cases
        for (int p = 0; p < 24; p++) begin
            for (int v = 0; v < 2; v++) begin
                logic [23:0] x;
                logic [24:0] c;
                int k;
                x = (v == 0) ? (24'h1 << p) : ~(24'h1 << p);
                c = {p[0], x};
                k = norm_count(x);
                msc = 5'(k);
                run_op(3'd1, 5'd0, c, 0, c << k, msc, k + 2, "R7");
            end
        end
        begin
            logic [23:0] xs [0:3] = '{24'h000000, 24'hFFFFFF, 24'h400000, 24'h123456};
            for (int i = 0; i < 4; i++) begin
                logic [24:0] c;
                int k;
                c = {1'b1, xs[i]};
                k = norm_count(xs[i]);
                msc = 5'(k);
                run_op(3'd1, 5'd3, c, 0, c << k, msc, k + 2, "R7");
            end
        end

        // R11: unused codes
        for (int o = 5; o < 8; o++) begin
            logic [24:0] c;
            c = {o[0], 12'(o * 1111), 12'(o * 333)};
            run_op(3'(o), 5'(o), c, 0, c, msc, 1, "R11");
        end

        // R10: start pulse during a long shift has no effect
        run_op(3'd2, 5'd20, 25'h0_00ABCD, 1,
               model_shift(3'd2, 25'h0_00ABCD, 21), msc, 23, "R10");
        run_op(3'd3, 5'd9, 25'h0_F01234, 1,
               model_shift(3'd3, 25'h0_F01234, 10), msc, 12, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule